// File: doc/BRIEF.md
# Test Access Port Controller with Status-Capturing Instruction Register

This block is the controller for a serial test port that follows the IEEE 1149.1 state machine. It runs only from its own test clock `tck` and is reset asynchronously only by `trst_n`. It never uses the core clock or the core reset. A static compliance level `comply_en` must also be high; while it is low, the test logic is held in its reset state. A sixteen-state controller steps on each rising `tck` edge under `tms`. The controller selects either an instruction path or a data path between `tdi` and the serial output.

The instruction register is four bits wide by default. On capture, its two lowest bits always load the pattern 01. The bits above them take a snapshot of live device status. Bit 2 is the self-test go flag `bist_go`, and the higher bits come from `dev_flags`. This lets a board tester read pass/fail information during every instruction scan. Three operations are decoded:

- driving pins from the boundary chain;
- sampling or preloading the chain;
- a one-bit bypass path.

The boundary chain is external. It receives capture, shift and update strobes and returns its serial output on `bsr_so`. The serial output changes on falling `tck` edges. Its enable is high only while a shift state is active, so the pad is high impedance at all other times.

Top module: `tap_ctrl`

## Requirements
- R1: While `trst_n` is low, the following hold immediately: `tdo_oe`=0, `io_safe`=1, `extest_en`=0, and the instruction register holds BYPASS. This does not wait for a clock edge.
- R2: Five consecutive rising `tck` edges with `tms`=1 bring the controller to test-logic-reset (`io_safe`=1) from any state. At the following falling edge, the instruction register is reloaded with BYPASS.
- R3: Capture-IR loads {`dev_flags`, `bist_go`, 1'b0, 1'b1} into the instruction shift register, so bit 0 is 1, bit 1 is 0 and bit 2 is `bist_go`. Shift-IR moves the register towards bit 0, and bit 0 appears on `tdo` first.
- R4: `tdo_oe` is 1 exactly while the controller is in shift-DR or shift-IR. Both `tdo_oe` and `tdo` change on falling `tck` edges.
- R5: The shifted instruction takes effect at the falling `tck` edge in update-IR and not earlier. The opcode encodings are:
  - 4'b0000 selects EXTEST;
  - 4'b0010 selects SAMPLE/PRELOAD;
  - 4'b1111 and every other code select BYPASS.
- R6: With BYPASS selected, capture-DR loads 0 into the bypass bit. Shift-DR then presents the captured 0 first, followed by `tdi` delayed by one `tck`.
- R7: `bsr_capture`, `bsr_shift` and `bsr_update` are high in capture-DR, shift-DR and update-DR respectively, and only when EXTEST or SAMPLE/PRELOAD is selected. In those modes, shift-DR presents `bsr_so` on `tdo`.
- R8: `io_safe` is 1 exactly while the controller is in test-logic-reset. `extest_en` is 1 exactly while EXTEST is the current instruction.
- R9: While `comply_en` is low, the test logic is held in reset with the same outputs as R1, and `tms` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| comply_en | input | 1 | Static compliance enable; low holds test logic in reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| bist_go | input | 1 | Self-test pass flag, captured into IR bit 2 |
| dev_flags | input | IR_W-3 | Further status captured into IR bits above bit 2 |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_oe | output | 1 | Output enable for the `tdo` pad |
| bsr_capture | output | 1 | Boundary chain capture strobe |
| bsr_shift | output | 1 | Boundary chain shift strobe |
| bsr_update | output | 1 | Boundary chain update strobe |
| extest_en | output | 1 | Boundary cells drive the pins |
| io_safe | output | 1 | Force boundary I/O to input or high impedance |

## Verification
State changes and the strobes that decode them are valid one rising edge after the `tms` value that causes them. The bench sets `tms` and `tdi` 1 ns after a rising edge and reads the strobes 1 ns after the next one. `tdo` and `tdo_oe` follow the falling edge that comes after the state change, and a new instruction appears only at the falling edge inside update-IR. The bench therefore reads those outputs 1 ns after that falling edge, including one check in update-IR before the edge to confirm that `extest_en` has not yet changed. The effects of `trst_n` and `comply_en` take no clock edge, and they are checked 1 ns after the level changes.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    S_RESET  = 4'd0,
    S_IDLE   = 4'd1,
    S_SEL_DR = 4'd2,
    S_CAP_DR = 4'd3,
    S_SH_DR  = 4'd4,
    S_EX1_DR = 4'd5,
    S_PA_DR  = 4'd6,
    S_EX2_DR = 4'd7,
    S_UP_DR  = 4'd8,
    S_SEL_IR = 4'd9,
    S_CAP_IR = 4'd10,
    S_SH_IR  = 4'd11,
    S_EX1_IR = 4'd12,
    S_PA_IR  = 4'd13,
    S_EX2_IR = 4'd14,
    S_UP_IR  = 4'd15
  } tap_state_e;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    tap_state_e n;
    case (s)
      S_RESET:  n = m ? S_RESET  : S_IDLE;
      S_IDLE:   n = m ? S_SEL_DR : S_IDLE;
      S_SEL_DR: n = m ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: n = m ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  n = m ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: n = m ? S_UP_DR  : S_PA_DR;
      S_PA_DR:  n = m ? S_EX2_DR : S_PA_DR;
      S_EX2_DR: n = m ? S_UP_DR  : S_SH_DR;
      S_UP_DR:  n = m ? S_SEL_DR : S_IDLE;
      S_SEL_IR: n = m ? S_RESET  : S_CAP_IR;
      S_CAP_IR: n = m ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  n = m ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: n = m ? S_UP_IR  : S_PA_IR;
      S_PA_IR:  n = m ? S_EX2_IR : S_PA_IR;
      S_EX2_IR: n = m ? S_UP_IR  : S_SH_IR;
      default:  n = m ? S_SEL_DR : S_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= S_RESET;
    else        state <= tap_next(state, tms);
  end

  AST_FIVE_TMS_RESET: assert property (@(posedge tck) disable iff (!rst_n)
    ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
      |-> (state == S_RESET)); // R2

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
#(
  parameter int IR_W = 4
) (
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  input  logic [IR_W-3:0] status,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_so
);

  localparam logic [IR_W-1:0] OP_BYP = '1;

  logic [IR_W-1:0] sr;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                sr <= OP_BYP;
    else if (state == S_CAP_IR) sr <= {status, 2'b01};
    else if (state == S_SH_IR)  sr <= {tdi, sr[IR_W-1:1]};
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)                ir_q <= OP_BYP;
    else if (state == S_RESET) ir_q <= OP_BYP;
    else if (state == S_UP_IR) ir_q <= sr;
  end

  assign ir_so = sr[0];

  AST_IR_CAPTURE_LOW: assert property (@(posedge tck) disable iff (!rst_n)
    (state == S_CAP_IR) |=> (sr[1:0] == 2'b01)); // R3

  AST_IR_RESET_BYPASS: assert property (@(posedge tck) disable iff (!rst_n)
    (state == S_RESET && $past(state) == S_RESET) |-> (ir_q == OP_BYP)); // R1

  AST_IR_CHANGE_WHEN: assert property (@(posedge tck) disable iff (!rst_n)
    (ir_q != $past(ir_q)) |-> (state == S_UP_IR || state == S_RESET)); // R5

endmodule

// File: rtl/tap_bypass.sv
module tap_bypass
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e state,
  input  logic       tdi,
  output logic       byp_q
);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                 byp_q <= 1'b0;
    else if (state == S_CAP_DR) byp_q <= 1'b0;
    else if (state == S_SH_DR)  byp_q <= tdi;
  end

  AST_BYP_CAPTURE_ZERO: assert property (@(posedge tck) disable iff (!rst_n)
    (state == S_CAP_DR) |=> (byp_q == 1'b0)); // R6

endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
#(
  parameter int              IR_W      = 4,
  parameter logic [IR_W-1:0] OP_EXTEST = '0,
  parameter logic [IR_W-1:0] OP_SAMPLE = IR_W'(2)
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            comply_en,
  input  logic            tms,
  input  logic            tdi,
  input  logic            bist_go,
  input  logic [IR_W-4:0] dev_flags,
  input  logic            bsr_so,
  output logic            tdo,
  output logic            tdo_oe,
  output logic            bsr_capture,
  output logic            bsr_shift,
  output logic            bsr_update,
  output logic            extest_en,
  output logic            io_safe
);

  localparam int STAT_W = IR_W - 2;

  logic              rst_n;
  tap_state_e        state;
  logic [IR_W-1:0]   ir_q;
  logic              ir_so;
  logic              byp_q;
  logic [STAT_W-1:0] status;
  logic              chain_sel;
  logic              in_shift_ir;
  logic              in_shift_dr;

  assign rst_n  = trst_n & comply_en;
  assign status = {dev_flags, bist_go};

  tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  tap_ir #(.IR_W(IR_W)) u_ir (
    .tck    (tck),
    .rst_n  (rst_n),
    .state  (state),
    .tdi    (tdi),
    .status (status),
    .ir_q   (ir_q),
    .ir_so  (ir_so)
  );

  tap_bypass u_byp (
    .tck   (tck),
    .rst_n (rst_n),
    .state (state),
    .tdi   (tdi),
    .byp_q (byp_q)
  );

  assign in_shift_ir = (state == S_SH_IR);
  assign in_shift_dr = (state == S_SH_DR);
  assign chain_sel   = (ir_q == OP_EXTEST) || (ir_q == OP_SAMPLE);
  assign extest_en   = (ir_q == OP_EXTEST);
  assign io_safe     = (state == S_RESET);
  assign bsr_capture = chain_sel && (state == S_CAP_DR);
  assign bsr_shift   = chain_sel && in_shift_dr;
  assign bsr_update  = chain_sel && (state == S_UP_DR);

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= in_shift_ir || in_shift_dr;
      if (in_shift_ir)    tdo <= ir_so;
      else if (chain_sel) tdo <= bsr_so;
      else                tdo <= byp_q;
    end
  end

  AST_OE_SHIFT_ONLY: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe == (state == S_SH_DR || state == S_SH_IR)); // R4

  AST_CHAIN_STROBE_MODE: assert property (@(posedge tck) disable iff (!rst_n)
    (bsr_capture || bsr_shift || bsr_update) |-> (ir_q == OP_EXTEST || ir_q == OP_SAMPLE)); // R7

  AST_RESET_SAFE: assert property (@(posedge tck) disable iff (!rst_n)
    io_safe |-> !tdo_oe && !bsr_shift); // R8

endmodule

// File: tb/tap_ctrl_tb.sv
module tap_ctrl_tb;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic comply_en = 1'b1;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic bist_go = 1'b0;
  logic [0:0] dev_flags = 1'b0;
  logic bsr_so = 1'b1;
  logic tdo, tdo_oe, bsr_capture, bsr_shift, bsr_update, extest_en, io_safe;

  int checks = 0;
  int errors = 0;

  always #5 tck = ~tck;

  tap_ctrl u_dut (
    .tck(tck), .trst_n(trst_n), .comply_en(comply_en), .tms(tms), .tdi(tdi),
    .bist_go(bist_go), .dev_flags(dev_flags), .bsr_so(bsr_so),
    .tdo(tdo), .tdo_oe(tdo_oe), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
    .bsr_update(bsr_update), .extest_en(extest_en), .io_safe(io_safe)
  );

  // {opcode[3:0], bist_go, flag, expect extest, expect chain selected}
  localparam logic [7:0] VEC [5] = '{
    8'b0000_1_0_1_1,
    8'b0010_0_1_0_1,
    8'b1111_1_1_0_0,
    8'b0101_0_0_0_0,
    8'b0001_1_0_0_0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    #1;
  endtask

  // From run-test/idle: scan a new instruction, return the captured value.
  task automatic shift_ir(input logic [3:0] val, output logic [3:0] got,
                          output logic oe_all, output logic oe_after);
    oe_all = 1'b1;
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge tck); #1;
      got[i] = tdo;
      oe_all = oe_all & tdo_oe;
      tms = (i == 3);
      tdi = val[i];
      @(posedge tck); #1;
    end
    @(negedge tck); #1;
    oe_after = tdo_oe;
    tick(1, 0); tick(0, 0);
  endtask

  // From run-test/idle: four-bit data scan with tdi pattern 1,0,1,1.
  task automatic shift_dr(output logic [3:0] got, output logic cap, output logic sh,
                          output logic upd);
    logic [3:0] pat;
    pat = 4'b1101;
    sh = 1'b0;
    tick(1, 0); tick(0, 0);
    cap = bsr_capture;
    tick(0, 0);
    for (int i = 0; i < 4; i++) begin
      sh = sh | bsr_shift;
      @(negedge tck); #1;
      got[i] = tdo;
      tms = (i == 3);
      tdi = pat[i];
      @(posedge tck); #1;
    end
    tick(1, 0);
    upd = bsr_update;
    tick(0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge tck);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] got;
    logic oe_all, oe_after, cap, sh, upd;

    // Reset state
    repeat (3) @(posedge tck);
    #1;
    chk("R1 tdo_oe in reset", tdo_oe, 0);
    chk("R1 extest_en in reset", extest_en, 0);
    chk("R8 io_safe in reset", io_safe, 1);
    trst_n = 1'b1;
    tick(0, 0);
    chk("R8 io_safe leaves reset", io_safe, 0);

    // Vector table walk
    for (int v = 0; v < 5; v++) begin
      bist_go   = VEC[v][3];
      dev_flags = VEC[v][2];
      shift_ir(VEC[v][7:4], got, oe_all, oe_after);
      chk("R3 IR capture value", got, {VEC[v][2], VEC[v][3], 2'b01});
      chk("R4 tdo_oe during shift-IR", oe_all, 1);
      chk("R4 tdo_oe after shift-IR", oe_after, 0);
      chk("R5 R8 extest_en decode", extest_en, VEC[v][1]);
      shift_dr(got, cap, sh, upd);
      chk("R7 capture strobe", cap, VEC[v][0]);
      chk("R7 shift strobe", sh, VEC[v][0]);
      chk("R7 update strobe", upd, VEC[v][0]);
      chk("R6 R7 DR path on tdo", got, VEC[v][0] ? 4'b1111 : 4'b1010);
    end

    // R5: new instruction only at falling edge in update-IR
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    tick(0, 0); tick(0, 0); tick(0, 0); tick(1, 0);
    chk("R5 no change in exit1-IR", extest_en, 0);
    tick(1, 0);
    chk("R5 no change before update edge", extest_en, 0);
    @(negedge tck); #1;
    chk("R5 change at update falling edge", extest_en, 1);
    tick(0, 0);

    // R2: five TMS-high edges from shift-DR
    tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R2 not in reset while shifting", io_safe, 0);
    for (int k = 0; k < 5; k++) tick(1, 0);
    chk("R2 reached test-logic-reset", io_safe, 1);
    @(negedge tck); #1;
    chk("R2 IR back to BYPASS", extest_en, 0);
    tick(0, 0);

    // R1: asynchronous trst_n in the middle of a scan
    shift_ir(4'b0000, got, oe_all, oe_after);
    tick(1, 0); tick(0, 0); tick(0, 0);
    @(negedge tck); #1;
    chk("R4 tdo_oe in shift-DR", tdo_oe, 1);
    #1 trst_n = 1'b0;
    #1;
    chk("R1 async tdo_oe", tdo_oe, 0);
    chk("R1 async extest_en", extest_en, 0);
    chk("R1 async io_safe", io_safe, 1);
    trst_n = 1'b1;
    tick(0, 0);

    // R9: compliance level held low
    shift_ir(4'b0000, got, oe_all, oe_after);
    tick(1, 0); tick(0, 0); tick(0, 0);
    #1 comply_en = 1'b0;
    #1;
    chk("R9 extest_en with comply low", extest_en, 0);
    chk("R9 io_safe with comply low", io_safe, 1);
    tick(0, 0); tick(0, 0);
    chk("R9 tms ignored with comply low", io_safe, 1);
    @(negedge tck); #1;
    chk("R9 tdo_oe with comply low", tdo_oe, 0);
    comply_en = 1'b1;
    tick(0, 0);
    chk("R9 runs after comply high", io_safe, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule